// File: doc/BRIEF.md
# ALU Condition Flag Unit

This block adds or subtracts two WIDTH-bit operands and derives six processor condition flags from the operation. The arithmetic result is combinational and follows the operands in the same cycle. The flags are registered: negative, zero, signed overflow, carry/borrow, nibble carry/borrow and even parity. A datapath drives the operands and the add/subtract select, then raises the update enable on the cycles whose outcome should become the visible condition state.

Subtraction is computed as `op_a + ~op_b + 1`. For a subtract, both carry-type flags report a borrow rather than the raw adder carry. When the update enable is low, the flag register keeps its contents. A synchronous reset clears every flag.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` equals `op_a + op_b` modulo 2^WIDTH when `op_sub` is 0, and `op_a - op_b` modulo 2^WIDTH when `op_sub` is 1, in the same cycle.
- R2: On a clock edge with `flag_en` high, `flag_n` takes bit WIDTH-1 of the result.
- R3: On a clock edge with `flag_en` high, `flag_z` becomes 1 exactly when the result is all zeros.
- R4: On a clock edge with `flag_en` high, `flag_v` becomes 1 exactly when the true signed sum or difference of the operands falls outside the WIDTH-bit two's-complement range.
- R5: On a clock edge with `flag_en` high, `flag_c` takes the carry out of bit WIDTH-1 for an add. For a subtract it becomes 1 exactly when `op_a < op_b` as unsigned numbers (borrow).
- R6: On a clock edge with `flag_en` high, `flag_a` takes the carry from bit 3 into bit 4 for an add. For a subtract it becomes 1 exactly when `op_a[3:0] < op_b[3:0]` (nibble borrow).
- R7: On a clock edge with `flag_en` high, `flag_p` becomes 1 exactly when `result[7:0]` holds an even number of ones. Bits above bit 7 have no effect on it.
- R8: On a clock edge with `flag_en` low and `rst` low, all six flags keep their values.
- R9: On a clock edge with `rst` high, all six flags become 0, whatever the value of `flag_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | WIDTH | First operand (minuend) |
| op_b | input | WIDTH | Second operand (subtrahend) |
| op_sub | input | 1 | 1 selects subtract, 0 selects add |
| flag_en | input | 1 | Flag register update enable |
| result | output | WIDTH | Sum or difference |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry (add) or borrow (subtract) |
| flag_a | output | 1 | Nibble carry or borrow at bit 3 |
| flag_p | output | 1 | Even parity of the low result byte |

## Verification
The bench builds the unit with WIDTH = 16. At this width the nibble boundary, the parity byte and the sign bit fall at three separate positions. Directed operands can therefore set one of these flags without the others: for example, a result with odd high-byte ones and an even low byte. The sign crossings at 0x7FFF/0x8000 and the full wrap at 0xFFFF are reached directly, and a run of random operands covers the flag combinations between them.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic a;
        logic p;
    } flag_set_t;

    localparam int unsigned NIBBLE_W = 4;
    localparam int unsigned PARITY_W = 8;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_top,
    output logic             carry_nib
);
    import alu_flag_pkg::*;

    localparam int unsigned NW = NIBBLE_W;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;
    logic [NW:0]      low;

    always_comb begin
        b_eff     = sub ? ~op_b : op_b;
        wide      = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        low       = {1'b0, op_a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, sub};
        sum       = wide[WIDTH-1:0];
        carry_top = wide[WIDTH];
        carry_nib = low[NW];
    end

endmodule

// File: rtl/alu_parity.sv
module alu_parity #(
    parameter int unsigned PW = 8
) (
    input  logic [PW-1:0] data,
    output logic          even
);
    logic [PW:0] chain;

    assign chain[0] = 1'b0;

    for (genvar gi = 0; gi < PW; gi++) begin : g_xor
        assign chain[gi+1] = chain[gi] ^ data[gi];
    end

    assign even = ~chain[PW];

endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0]         sum,
    input  logic                     sub,
    input  logic                     a_msb,
    input  logic                     b_msb,
    input  logic                     carry_top,
    input  logic                     carry_nib,
    input  logic                     parity_even,
    output alu_flag_pkg::flag_set_t  flags
);
    logic same_sign;

    always_comb begin
        // operands agree in sign (add) or differ (subtract)
        same_sign = sub ? (a_msb != b_msb) : (a_msb == b_msb);
        flags.n   = sum[WIDTH-1];
        flags.z   = (sum == '0);
        flags.v   = same_sign && (sum[WIDTH-1] != a_msb);
        flags.c   = sub ? ~carry_top : carry_top;
        flags.a   = sub ? ~carry_nib : carry_nib;
        flags.p   = parity_even;
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             op_sub,
    input  logic             flag_en,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c,
    output logic             flag_a,
    output logic             flag_p
);
    import alu_flag_pkg::*;

    localparam int unsigned PW = PARITY_W;

    logic [WIDTH-1:0] sum_w;
    logic             carry_top_w;
    logic             carry_nib_w;
    logic             par_even_w;
    flag_set_t        calc_w;
    flag_set_t        flags_d;
    flag_set_t        flags_q;

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .op_a      (op_a),
        .op_b      (op_b),
        .sub       (op_sub),
        .sum       (sum_w),
        .carry_top (carry_top_w),
        .carry_nib (carry_nib_w)
    );

    alu_parity #(.PW(PW)) u_parity (
        .data (sum_w[PW-1:0]),
        .even (par_even_w)
    );

    alu_flag_calc #(.WIDTH(WIDTH)) u_calc (
        .sum         (sum_w),
        .sub         (op_sub),
        .a_msb       (op_a[WIDTH-1]),
        .b_msb       (op_b[WIDTH-1]),
        .carry_top   (carry_top_w),
        .carry_nib   (carry_nib_w),
        .parity_even (par_even_w),
        .flags       (calc_w)
    );

    always_comb begin
        if (rst) begin
            flags_d = '0;
        end else if (flag_en) begin
            flags_d = calc_w;
        end else begin
            flags_d = flags_q;
        end
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign result = sum_w;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;
    assign flag_a = flags_q.a;
    assign flag_p = flags_q.p;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             op_sub,
    input logic             flag_en,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_v,
    input logic             flag_c,
    input logic             flag_a,
    input logic             flag_p
);
    logic [WIDTH-1:0]  ref_res;
    logic [WIDTH:0]    wide_add;
    logic [4:0]        nib_add;
    logic signed [WIDTH:0] sgn_ext;
    logic              ref_c;
    logic              ref_a;
    logic              ref_v;
    logic [5:0]        all_flags;

    always_comb begin
        ref_res  = op_sub ? (op_a - op_b) : (op_a + op_b);
        wide_add = {1'b0, op_a} + {1'b0, op_b};
        nib_add  = {1'b0, op_a[3:0]} + {1'b0, op_b[3:0]};
        sgn_ext  = op_sub ? ($signed({op_a[WIDTH-1], op_a}) - $signed({op_b[WIDTH-1], op_b}))
                          : ($signed({op_a[WIDTH-1], op_a}) + $signed({op_b[WIDTH-1], op_b}));
        ref_c    = op_sub ? (op_a < op_b) : wide_add[WIDTH];
        ref_a    = op_sub ? (op_a[3:0] < op_b[3:0]) : nib_add[4];
        ref_v    = sgn_ext[WIDTH] != sgn_ext[WIDTH-1];
        all_flags = {flag_n, flag_z, flag_v, flag_c, flag_a, flag_p};
    end

    // R1
    sum_value_chk: assert property (@(posedge clk) disable iff (rst)
        result == ref_res);

    // R2
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_en |=> flag_n == $past(ref_res[WIDTH-1]));

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_en |=> flag_z == $past(ref_res == '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        flag_en |=> flag_v == $past(ref_v));

    // R5
    carry_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_en |=> flag_c == $past(ref_c));

    // R6
    nib_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_en |=> flag_a == $past(ref_a));

    // R7
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_en |=> flag_p == $past($countones(ref_res[7:0]) % 2 == 0));

    // R8
    hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_en |=> $stable(all_flags));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> all_flags == 6'b0);

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_sub  (op_sub),
    .flag_en (flag_en),
    .result  (result),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_v  (flag_v),
    .flag_c  (flag_c),
    .flag_a  (flag_a),
    .flag_p  (flag_p)
);

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         op_sub = 1'b0;
    logic         flag_en = 1'b0;
    logic [W-1:0] result;
    logic         flag_n, flag_z, flag_v, flag_c, flag_a, flag_p;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_q[$];
    logic [5:0] model = '0;
    bit done = 0;

    always #10 clk = ~clk;

    alu_flag_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .flag_en(flag_en), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .flag_a(flag_a), .flag_p(flag_p)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] calc(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        logic [W-1:0] r;
        longint sa, sb, st;
        logic n, z, v, c, ax, p;
        r  = s ? a - b : a + b;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        st = s ? sa - sb : sa + sb;
        n  = r[W-1];
        z  = (r == 0);
        v  = (st > 32767) || (st < -32768);
        c  = s ? (a < b) : ((int'(a) + int'(b)) > 65535);
        ax = s ? (a[3:0] < b[3:0]) : ((int'(a[3:0]) + int'(b[3:0])) > 15);
        p  = ($countones(r[7:0]) % 2) == 0;
        return {n, z, v, c, ax, p};
    endfunction

    // driver: one cycle per call, pushes the flags expected after the next edge
    task automatic apply(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input logic en);
        logic [W-1:0] er;
        @(negedge clk);
        rst = r; op_a = a; op_b = b; op_sub = s; flag_en = en;
        #1;
        er = s ? a - b : a + b;
        check(result == er, "R1 result", result, er);
        if (r) model = '0;               // R9
        else if (en) model = calc(a, b, s);
        // else R8: model holds
        exp_q.push_back(model);
    endtask

    // monitor: compares each flag after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [5:0] e;
                e = exp_q.pop_front();
                check(flag_n == e[5], "R2 N (R8/R9 hold/reset)", flag_n, e[5]);
                check(flag_z == e[4], "R3 Z (R8/R9 hold/reset)", flag_z, e[4]);
                check(flag_v == e[3], "R4 V (R8/R9 hold/reset)", flag_v, e[3]);
                check(flag_c == e[2], "R5 C (R8/R9 hold/reset)", flag_c, e[2]);
                check(flag_a == e[1], "R6 A (R8/R9 hold/reset)", flag_a, e[1]);
                check(flag_p == e[0], "R7 P (R8/R9 hold/reset)", flag_p, e[0]);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state, and reset wins over enable
        apply(1, 16'hFFFF, 16'h0001, 0, 0);
        apply(1, 16'hFFFF, 16'h0001, 0, 1);
        // R2 R4 R6 R7: 0x7FFF + 1 -> 0x8000
        apply(0, 16'h7FFF, 16'h0001, 0, 1);
        // R3 R5: 0xFFFF + 1 wraps to zero with carry
        apply(0, 16'hFFFF, 16'h0001, 0, 1);
        // R5 R6: borrow on 5 - 7
        apply(0, 16'h0005, 16'h0007, 1, 1);
        // R4: 0x8000 - 1 overflows
        apply(0, 16'h8000, 16'h0001, 1, 1);
        // R7: high byte has odd ones, low byte even -> P stays 1
        apply(0, 16'h0100, 16'h0003, 0, 1);
        // R8: disabled updates leave flags alone
        apply(0, 16'h0000, 16'h0000, 0, 0);
        apply(0, 16'hFFFF, 16'hFFFF, 1, 0);
        // R9 after activity
        apply(1, 16'h1234, 16'h0001, 1, 1);
        // random mix
        for (int i = 0; i < 300; i++) begin
            apply((i % 97) == 96, W'($urandom), W'($urandom), 1'($urandom), 1'(($urandom % 4) != 0));
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule